// File: doc/BRIEF.md
# Iterative AES-128 Block Cipher Engine

The engine encrypts or decrypts one 128-bit block at a time with AES-128 in electronic-codebook fashion. One datapath serves both directions. It works on one 32-bit column per clock, so each round takes four clocks. It does not hold the key schedule. Instead it drives a round index to an external round-key store and reads back the 128-bit round key for that index in the same cycle. The store, key loading and key expansion sit outside this block.

Every block takes exactly 44 clock cycles in which the enable input is high. While enable is low, all progress freezes. A one-cycle synchronous clear throws away the block in flight, and the next block may start on the following cycle. Because the key store is external, a clear leaves the key material and the key-ready flag untouched. Results are shown for one cycle only, marked by a valid strobe, so the user must capture `data_o` when `valid_o` is high.

Top module: `aes_iter_core`

## Requirements
- R1: After reset `valid_o` is 0 and `data_o` is all zeros. With `enc_i`=1 and no block running, `rk_idx_o` is 0.
- R2: With `enc_i`=1 the result is the AES-128 encryption of `data_i`. Byte 0 of the block is `data_i[127:120]` and round key k is the store word at index k. The result must match the published known-answer vectors.
- R3: With `enc_i`=0 the result is the AES-128 decryption of `data_i`. Round keys are applied from index 10 down to index 0.
- R4: `valid_o` is high for exactly one cycle per block. That cycle is the 44th enabled cycle, counting from the cycle in which `data_i` is sampled, and `data_o` holds the result in that cycle.
- R5: While `en_i` stays high, the cycle after the valid cycle samples a new `data_i`. Blocks therefore stream with one result every 44 cycles, and the direction may change between blocks.
- R6: A cycle with `en_i`=0 changes no internal state. After any number of such cycles, the block resumes where it stopped. It gives the same result, later by the number of paused cycles.
- R7: `clr_i` high for one cycle discards the current block, and that block never produces `valid_o`. A new block may start on the next cycle and complete normally. `clr_i` takes priority over `en_i`.
- R8: A block starts only when `key_rdy_i`=1. With `key_rdy_i`=0, a high `en_i` starts nothing and `data_o` keeps its value.
- R9: With no block running, `rk_idx_o` shows the first key the next block will use: 0 when `enc_i`=1 and 10 when `enc_i`=0. It never exceeds 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance enable; low freezes the engine |
| clr_i | input | 1 | Synchronous flush of the block in flight |
| enc_i | input | 1 | 1 = encrypt, 0 = decrypt; hold for a whole block |
| key_rdy_i | input | 1 | Round-key store holds an expanded key |
| data_i | input | 128 | Input block, sampled on the first cycle of a block |
| rk_i | input | 128 | Round key read from the store at `rk_idx_o` |
| rk_idx_o | output | 4 | Round-key read index (0 to 10) |
| data_o | output | 128 | Result block |
| valid_o | output | 1 | One-cycle strobe marking `data_o` as the result |

## Verification
A corrupted column, a wrong shift offset or a wrong round-key index spreads across the whole 128-bit block within one or two rounds. The result then differs from the known-answer value on the very valid cycle of that block. A step counter that drifts, fails to freeze or fails to flush shows up differently: the valid strobe appears in the wrong cycle, appears for an aborted block, or is missing. The scoreboard catches each of these at the first result affected, because it pairs every result with the exact cycle it expects.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int BLK_W = 128;
  localparam int COL_W = 32;
  localparam int NB    = 4;
  localparam int NR    = 10;
  localparam int CW    = $clog2(NB);
  localparam int RW    = $clog2(NR + 1);

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  // x^254 by square-and-multiply; 0 maps to 0
  function automatic logic [7:0] ginv(input logic [7:0] x);
    logic [7:0] p, r;
    p = x;
    r = 8'h01;
    for (int i = 0; i < 7; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] b;
    b = ginv(x);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_sbox(input logic [7:0] x);
    return ginv(rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05);
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
            xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
  endfunction

  function automatic logic [31:0] inv_mix_col(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {gmul(a0, 8'd14) ^ gmul(a1, 8'd11) ^ gmul(a2, 8'd13) ^ gmul(a3, 8'd9),
            gmul(a0, 8'd9)  ^ gmul(a1, 8'd14) ^ gmul(a2, 8'd11) ^ gmul(a3, 8'd13),
            gmul(a0, 8'd13) ^ gmul(a1, 8'd9)  ^ gmul(a2, 8'd14) ^ gmul(a3, 8'd11),
            gmul(a0, 8'd11) ^ gmul(a1, 8'd13) ^ gmul(a2, 8'd9)  ^ gmul(a3, 8'd14)};
  endfunction
endpackage

// File: rtl/aes_col_fwd.sv
module aes_col_fwd
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [CW-1:0]    col_i,
  input  logic             last_i,
  input  logic [COL_W-1:0] rk_col_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sub_w;

  // row r takes its byte from column col+r (shift rows folded into the read)
  for (genvar r = 0; r < NB; r++) begin : g_row
    logic [CW-1:0] src;
    assign src = col_i + CW'(r);
    assign sub_w[COL_W-1-8*r -: 8] = sbox(state_i[BLK_W-1-COL_W*src-8*r -: 8]);
  end

  assign col_o = (last_i ? sub_w : mix_col(sub_w)) ^ rk_col_i;
endmodule

// File: rtl/aes_col_inv.sv
module aes_col_inv
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [CW-1:0]    col_i,
  input  logic             last_i,
  input  logic [COL_W-1:0] rk_col_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sub_w, ark_w;

  // inverse shift: row r takes its byte from column col-r
  for (genvar r = 0; r < NB; r++) begin : g_row
    logic [CW-1:0] src;
    assign src = col_i - CW'(r);
    assign sub_w[COL_W-1-8*r -: 8] = inv_sbox(state_i[BLK_W-1-COL_W*src-8*r -: 8]);
  end

  assign ark_w = sub_w ^ rk_col_i;
  assign col_o = last_i ? ark_w : inv_mix_col(ark_w);
endmodule

// File: rtl/aes_iter_ctrl.sv
module aes_iter_ctrl
  import aes_pkg::*;
#(
  parameter int LATENCY = 44
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic          enc_i,
  input  logic          key_rdy_i,
  output logic          load_o,
  output logic          col_act_o,
  output logic [CW-1:0] col_o,
  output logic          last_rnd_o,
  output logic [RW-1:0] rk_idx_o,
  output logic          valid_o
);
  localparam int SW          = $clog2(LATENCY);
  localparam int ROUND_STEPS = NR * NB;
  localparam int LAST        = LATENCY - 1;

  logic [SW-1:0] step_q, rel;
  logic [RW-1:0] rnd;
  logic          idle, in_rnd, advance;

  assign idle    = (step_q == '0);
  assign in_rnd  = !idle && (step_q <= SW'(ROUND_STEPS));
  assign advance = en_i && (!idle || key_rdy_i);
  assign rel     = step_q - SW'(1);
  assign rnd     = RW'(rel >> CW) + RW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      step_q <= '0;
    else if (clr_i)   step_q <= '0;
    else if (advance) step_q <= (step_q == SW'(LAST)) ? '0 : step_q + SW'(1);
  end

  assign load_o     = en_i && !clr_i && idle && key_rdy_i;
  assign col_act_o  = en_i && !clr_i && in_rnd;
  assign col_o      = rel[CW-1:0];
  assign last_rnd_o = (rnd == RW'(NR));
  assign valid_o    = en_i && !clr_i && (step_q == SW'(LAST));

  always_comb begin
    if (idle)        rk_idx_o = enc_i ? '0 : RW'(NR);
    else if (in_rnd) rk_idx_o = enc_i ? rnd : RW'(NR) - rnd;
    else             rk_idx_o = '0;
  end

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r6_step_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(step_q));
  a_r7_clear_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (step_q == '0) && !valid_o);
  a_r8_wait_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !key_rdy_i) |=> idle);
  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> idle);
  a_r9_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rk_idx_o <= RW'(NR));
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
  import aes_pkg::*;
#(
  parameter int LATENCY = 44
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             enc_i,
  input  logic             key_rdy_i,
  input  logic [BLK_W-1:0] data_i,
  input  logic [BLK_W-1:0] rk_i,
  output logic [RW-1:0]    rk_idx_o,
  output logic [BLK_W-1:0] data_o,
  output logic             valid_o
);
  logic                      load, col_act, last_rnd;
  logic [CW-1:0]             col;
  logic [COL_W-1:0]          rk_col, fwd_col, inv_col, new_col;
  logic [BLK_W-1:0]          state_q, round_out;
  logic [NB-2:0][COL_W-1:0]  acc_q;

  aes_iter_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .clr_i, .enc_i, .key_rdy_i,
    .load_o(load), .col_act_o(col_act), .col_o(col), .last_rnd_o(last_rnd),
    .rk_idx_o, .valid_o
  );

  assign rk_col = rk_i[BLK_W-1-COL_W*col -: COL_W];

  aes_col_fwd u_fwd (.state_i(state_q), .col_i(col), .last_i(last_rnd),
                     .rk_col_i(rk_col), .col_o(fwd_col));
  aes_col_inv u_inv (.state_i(state_q), .col_i(col), .last_i(last_rnd),
                     .rk_col_i(rk_col), .col_o(inv_col));

  assign new_col = enc_i ? fwd_col : inv_col;

  // round result: columns gathered so far plus the one finished this cycle
  always_comb begin
    for (int c = 0; c < NB - 1; c++) round_out[BLK_W-1-COL_W*c -: COL_W] = acc_q[c];
    round_out[COL_W-1:0] = new_col;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      acc_q   <= '0;
    end else if (load) begin
      state_q <= data_i ^ rk_i;
    end else if (col_act) begin
      if (col == CW'(NB - 1)) state_q    <= round_out;
      else                    acc_q[col] <= new_col;
    end
  end

  assign data_o = state_q;

  a_r6_state_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(state_q));
  a_r8_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_rdy_i |-> !load);
endmodule

// File: tb/aes_iter_core_tb_top.sv
module aes_iter_core_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0, clr_i = 1'b0, enc_i = 1'b1, key_rdy_i = 1'b0;
  logic [127:0] data_i = '0;
  logic [127:0] rk_i;
  logic [3:0]   rk_idx_o;
  logic [127:0] data_o;
  logic         valid_o;

  aes_iter_core dut_i (.*);

  always #5 clk_i = ~clk_i;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // reference round-key store built by the bench
  logic [127:0] rks [0:10];
  assign rk_i = (rk_idx_o <= 4'd10) ? rks[rk_idx_o] : '0;

  // S-box from log/antilog tables (generator 3)
  logic [7:0] sb [0:255];
  function automatic logic [7:0] rl(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction
  initial begin
    logic [7:0] ex [0:254];
    int lg [0:255];
    logic [7:0] e, v;
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[i] = e; lg[e] = i;
      e = e ^ ({e[6:0], 1'b0} ^ (e[7] ? 8'h1b : 8'h00));
    end
    for (int x = 0; x < 256; x++) begin
      v = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
      sb[x] = v ^ rl(v, 1) ^ rl(v, 2) ^ rl(v, 3) ^ rl(v, 4) ^ 8'h63;
    end
  end

  task automatic set_key(input logic [127:0] key);
    logic [31:0] w [0:43];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rks[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [127:0] q_exp [$];
  int           q_cyc [$];
  string        q_tag [$];

  task automatic run_block(input logic [127:0] d, input logic enc, input logic [127:0] exp,
                           input string tag, input int pat, input int plen);
    data_i = d; enc_i = enc; en_i = 1'b1;
    q_exp.push_back(exp); q_cyc.push_back(cyc + 43 + plen); q_tag.push_back(tag);
    for (int e = 1; e <= 44; e++) begin
      if (e == pat) begin
        en_i = 1'b0;
        repeat (plen) @(negedge clk_i);
        en_i = 1'b1;
      end
      @(negedge clk_i);
    end
  endtask

  initial begin : monitor
    logic prev_v = 1'b0;
    forever begin
      @(negedge clk_i); #1;
      if (rst_ni) begin
        if (valid_o) begin
          if (q_exp.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R7/R4: unexpected valid at cycle %0d, data %h expected none", cyc, data_o);
          end else begin
            logic [127:0] ex; int ec; string tg;
            ex = q_exp.pop_front(); ec = q_cyc.pop_front(); tg = q_tag.pop_front();
            chk(tg, data_o, ex);
            n_chk++;
            if (cyc != ec) begin
              n_fail++;
              $display("FAIL R4 (%s): valid at cycle %0d expected cycle %0d", tg, cyc, ec);
            end
          end
          if (prev_v) begin
            n_chk++; n_fail++;
            $display("FAIL R4: valid high two cycles in a row, actual 1 expected 0");
          end
        end
        prev_v = valid_o;
      end
    end
  end

  localparam logic [127:0] K1  = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] P3  = 128'h6bc1bee22e409f96e93d7e117393172a;
  localparam logic [127:0] C3  = 128'h3ad77bb40d7a3660a89ecaf32466ef97;
  localparam logic [127:0] P4  = 128'hae2d8a571e03ac9c9eb76fac45af8e51;
  localparam logic [127:0] C4  = 128'hf5d3d58503b9699de785895a96fdbaaf;

  initial begin : driver
    for (int r = 0; r < 11; r++) rks[r] = '0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    // R1 reset state
    chk("R1 valid", {127'h0, valid_o}, 128'h0);
    chk("R1 data", data_o, 128'h0);
    chk("R1 index", {124'h0, rk_idx_o}, 128'h0);

    // R8: enable without key-ready starts nothing
    @(negedge clk_i);
    data_i = P1; en_i = 1'b1;
    repeat (60) @(negedge clk_i);
    #1 chk("R8 data unchanged", data_o, 128'h0);
    en_i = 1'b0;

    set_key(K1); key_rdy_i = 1'b1;
    @(negedge clk_i);
    enc_i = 1'b1; #1 chk("R9 idle enc index", {124'h0, rk_idx_o}, 128'd0);
    enc_i = 1'b0; #1 chk("R9 idle dec index", {124'h0, rk_idx_o}, 128'd10);
    @(negedge clk_i);

    run_block(P1, 1'b1, C1, "R2 enc K1", 0, 0);
    en_i = 1'b0; repeat (3) @(negedge clk_i);
    run_block(C1, 1'b0, P1, "R3 dec K1", 0, 0);
    en_i = 1'b0;

    set_key(K2);
    repeat (2) @(negedge clk_i);
    // R5 back-to-back stream with a direction change
    run_block(P2, 1'b1, C2, "R5 stream enc 1", 0, 0);
    run_block(P3, 1'b1, C3, "R5 stream enc 2", 0, 0);
    run_block(P4, 1'b1, C4, "R5 stream enc 3", 0, 0);
    run_block(C3, 1'b0, P3, "R5 stream dec", 0, 0);
    en_i = 1'b0; repeat (2) @(negedge clk_i);

    // R6 pause and resume
    run_block(P2, 1'b1, C2, "R6 pause enc", 3, 7);
    run_block(C4, 1'b0, P4, "R6 pause dec", 30, 5);
    en_i = 1'b0; repeat (2) @(negedge clk_i);

    // R7 abort then immediate restart
    data_i = P4; enc_i = 1'b1; en_i = 1'b1;
    repeat (10) @(negedge clk_i);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    run_block(P3, 1'b1, C3, "R7 after clear", 0, 0);
    en_i = 1'b0;
    // R7 clear during the valid cycle suppresses it
    @(negedge clk_i);
    data_i = C2; enc_i = 1'b0; en_i = 1'b1;
    repeat (43) @(negedge clk_i);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0; en_i = 1'b0;

    repeat (50) @(negedge clk_i);
    n_chk++;
    if (q_exp.size() != 0) begin
      n_fail++;
      $display("FAIL R4: %0d results missing, expected 0", q_exp.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R4: watchdog expired at cycle %0d, expected finish before 200000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule